// File: doc/BRIEF.md
# Real-Time Clock Core with Index/Data Host Access

This block keeps calendar time (seconds, minutes, hours, weekday, day of month, month and a two-digit year) in a small byte-wide register file. A host reaches every register through two strobes on a shared write bus. One strobe loads a register index, and the other writes the indexed byte. A read returns the indexed byte combinationally. Bit 7 of every index write is latched onto a separate mask output and takes no part in the address.

A one-cycle `tick` input stands for the once-per-second output of the oscillator divider. Each accepted tick raises an update-in-progress flag at once. The counters advance `LEAD_CYC` cycles later, and the flag stays high for `LEAD_CYC + HOLD_CYC` cycles in total. The control register selects BCD or binary storage and 12- or 24-hour form for every field. Stored bytes are interpreted in the current mode and are never converted when the mode changes. The control register also has a freeze bit that lets the host load a new time without the counters moving under it. A power-valid flag reports whether power has been lost since that flag was last read.

Top module: `rtc_core`

## Requirements
- R1: Index writes keep bits 6:0 as the register index and drive bit 7 onto `nmi_mask` from the next cycle. The time fields are at these indices: 0 seconds, 2 minutes, 4 hours, 6 weekday (1..7, Sunday is 1), 7 day (1..31), 8 month (1..12), 9 year (0..99). Status is at 10, control at 11 and power-valid at 13. Every other index (for example 1 and 12) reads 0x00 and ignores writes.
- R2: After reset the time is 00:00:00, with weekday 1, day 1, month 1 and year 0. The control register reads 0x02, the status register reads 0x26 and the power-valid register reads 0x00.
- R3: While the freeze bit is clear, a tick sampled on a clock edge sets status bit 7 (update in progress) from the following cycle. The time fields change exactly `LEAD_CYC` cycles after that flag rises. The flag stays high for `LEAD_CYC + HOLD_CYC` cycles, and any tick that arrives while it is high is ignored.
- R4: On an update, seconds 59 wraps to 0 and carries into minutes. Minutes 59 wraps to 0 and carries into hours. Hour 23 (24-hour form) wraps to 0 and carries into the weekday and the day.
- R5: The day wraps to 1 after the last day of its month. April, June, September and November have 30 days, and the other months have 31. February has 29 days when the binary year is divisible by 4 and 28 days otherwise.
- R6: The month wraps from 12 to 1 and carries into the year. The year wraps from 99 to 0, and the weekday wraps from 7 to 1.
- R7: With control bit 1 clear (12-hour form), the hour byte holds 1..12 and bit 7 is set for PM. 11 PM (0x91 in BCD) is followed by 12 AM (0x12). 12 PM (0x92) is followed by 1 PM (0x81). 11 AM (0x11) is followed by 12 PM (0x92).
- R8: With control bit 2 clear, every field is stored in BCD. With control bit 2 set, every field is stored in plain binary (seconds 59 is 0x3B). Changing either mode bit leaves the stored bytes unchanged.
- R9: While control bit 7 (freeze) is set, ticks are ignored, no update-in-progress flag is raised and no field advances. An update already in progress is dropped if the freeze bit is set before its counters would change. The host can still write the time fields while the freeze bit is set.
- R10: A host write to a time field that lands on the update cycle wins for that field. The other fields still take their updated values.
- R11: Power-valid bit 7 reads 0 after a power-loss pulse. A data read of index 13 sets it back to 1 for the next read. The other bits of that register read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle once-per-second update request |
| power_lost | input | 1 | Pulse reporting a loss of power |
| idx_we | input | 1 | Load the register index from `wdata` |
| data_we | input | 1 | Write `wdata` to the indexed register |
| data_re | input | 1 | Marks a data read of the indexed register |
| wdata | input | 8 | Host write data for index and data |
| rdata | output | 8 | Contents of the indexed register |
| nmi_mask | output | 1 | Bit 7 of the last index write |

## Verification
The update and a host data write can fall in the same clock edge. The bench parks the index on seconds and issues a tick. It then counts `LEAD_CYC` cycles and raises the data strobe so that it lands exactly on the update edge. The written second must survive, and the minute must still take its carry. A second collision places a write that sets the freeze bit inside the lead window, and that pending update must then be dropped. The behavioural model applies the update before the host write on each edge and judges both cases, while the update-in-progress flag is compared on every clock.

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int unsigned LEAD_CYC = 4,
  parameter int unsigned HOLD_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       power_lost,
  input  logic       idx_we,
  input  logic       data_we,
  input  logic       data_re,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       nmi_mask
);
  localparam int unsigned TOTAL = LEAD_CYC + HOLD_CYC;
  localparam int unsigned PH_W  = (TOTAL > 1) ? $clog2(TOTAL) : 1;
  localparam logic [PH_W-1:0] PH_UPD = PH_W'(LEAD_CYC - 1);
  localparam logic [PH_W-1:0] PH_END = PH_W'(TOTAL - 1);

  logic [7:0] r_sec, r_min, r_hr, r_wd, r_dom, r_mon, r_yr, r_b;
  logic [6:0] r_a, r_idx;
  logic       r_nmi, r_vrt, busy;
  logic [PH_W-1:0] ph;

  function automatic logic [6:0] dec(input logic [7:0] v, input logic b);
    return b ? v[6:0] : 7'({3'b0, v[7:4]} * 7'd10 + {3'b0, v[3:0]});
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] v, input logic b);
    logic [7:0] w;
    w = {1'b0, v};
    return b ? w : (w / 8'd10) * 8'd16 + (w % 8'd10);
  endfunction

  function automatic logic [6:0] mdays(input logic [6:0] mo, input logic [6:0] yr);
    case (mo)
      7'd2:                      return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   return 7'd30;
      default:                   return 7'd31;
    endcase
  endfunction

  wire bin  = r_b[2];
  wire h24m = r_b[1];
  wire frz  = r_b[7];

  logic [6:0] s, m, hv, h24, nh, h12, wd, d, mo, y;
  logic       cs, cm, ch, cd, cmo, pm;
  logic [7:0] n_sec, n_min, n_hr, n_wd, n_dom, n_mon, n_yr;

  always_comb begin
    s  = dec(r_sec, bin);
    m  = dec(r_min, bin);
    hv = dec({1'b0, r_hr[6:0]}, bin);
    wd = dec(r_wd, bin);
    d  = dec(r_dom, bin);
    mo = dec(r_mon, bin);
    y  = dec(r_yr, bin);
    if (h24m)          h24 = hv;
    else if (r_hr[7])  h24 = (hv == 7'd12) ? 7'd12 : hv + 7'd12;
    else               h24 = (hv == 7'd12) ? 7'd0 : hv;

    cs  = s >= 7'd59;
    cm  = cs && (m >= 7'd59);
    ch  = cm && (h24 >= 7'd23);
    cd  = ch && (d >= mdays(mo, y));
    cmo = cd && (mo >= 7'd12);

    nh  = ch ? 7'd0 : (cm ? h24 + 7'd1 : h24);
    pm  = nh >= 7'd12;
    h12 = (nh == 7'd0) ? 7'd12 : ((nh > 7'd12) ? nh - 7'd12 : nh);

    n_sec = cs ? enc(7'd0, bin) : enc(s + 7'd1, bin);
    n_min = cs ? enc(cm ? 7'd0 : m + 7'd1, bin) : r_min;
    n_hr  = !cm ? r_hr : (h24m ? enc(nh, bin) : (enc(h12, bin) | {pm, 7'b0}));
    n_wd  = ch ? enc((wd >= 7'd7) ? 7'd1 : wd + 7'd1, bin) : r_wd;
    n_dom = ch ? enc(cd ? 7'd1 : d + 7'd1, bin) : r_dom;
    n_mon = cd ? enc(cmo ? 7'd1 : mo + 7'd1, bin) : r_mon;
    n_yr  = cmo ? enc((y >= 7'd99) ? 7'd0 : y + 7'd1, bin) : r_yr;
  end

  wire do_upd = busy && (ph == PH_UPD) && !frz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_sec <= 8'h00; r_min <= 8'h00; r_hr <= 8'h00; r_wd <= 8'h01;
      r_dom <= 8'h01; r_mon <= 8'h01; r_yr <= 8'h00;
      r_a   <= 7'h26; r_b   <= 8'h02; r_idx <= '0;  r_nmi <= 1'b0;
      r_vrt <= 1'b0;  busy  <= 1'b0;  ph    <= '0;
    end else begin
      if (busy) begin
        ph <= ph + 1'b1;
        if (ph == PH_END) busy <= 1'b0;
      end else if (tick && !frz) begin
        busy <= 1'b1;
        ph   <= '0;
      end
      if (do_upd) begin
        r_sec <= n_sec; r_min <= n_min; r_hr <= n_hr; r_wd <= n_wd;
        r_dom <= n_dom; r_mon <= n_mon; r_yr <= n_yr;
      end
      if (data_we) begin
        case (r_idx)
          7'd0:  r_sec <= wdata;
          7'd2:  r_min <= wdata;
          7'd4:  r_hr  <= wdata;
          7'd6:  r_wd  <= wdata;
          7'd7:  r_dom <= wdata;
          7'd8:  r_mon <= wdata;
          7'd9:  r_yr  <= wdata;
          7'd10: r_a   <= wdata[6:0];
          7'd11: r_b   <= wdata;
          default: ;
        endcase
      end
      if (power_lost)                     r_vrt <= 1'b0;
      else if (data_re && r_idx == 7'd13) r_vrt <= 1'b1;
      if (idx_we) begin
        r_idx <= wdata[6:0];
        r_nmi <= wdata[7];
      end
    end
  end

  always_comb begin
    case (r_idx)
      7'd0:    rdata = r_sec;
      7'd2:    rdata = r_min;
      7'd4:    rdata = r_hr;
      7'd6:    rdata = r_wd;
      7'd7:    rdata = r_dom;
      7'd8:    rdata = r_mon;
      7'd9:    rdata = r_yr;
      7'd10:   rdata = {busy, r_a};
      7'd11:   rdata = r_b;
      7'd13:   rdata = {r_vrt, 7'b0};
      default: rdata = 8'h00;
    endcase
  end

  assign nmi_mask = r_nmi;
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk #(
  parameter int unsigned LEAD_CYC = 4,
  parameter int unsigned HOLD_CYC = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       idx_we,
  input logic       data_we,
  input logic [7:0] wdata,
  input logic       power_lost,
  input logic       nmi_mask,
  input logic       uip,
  input logic       frz,
  input logic [7:0] sec,
  input logic       vrt
);
  localparam int unsigned TOTAL = LEAD_CYC + HOLD_CYC;
  logic [15:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   run <= '0;
    else if (uip) run <= run + 16'd1;
    else          run <= '0;
  end

  AST_UIP_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    uip |-> run < 16'(TOTAL)); // R3
  AST_UIP_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> $past(tick)); // R3
  AST_IDLE_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !uip && !data_we |=> $stable(sec)); // R3
  AST_FROZEN_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    frz && !uip |=> !uip); // R9
  AST_FROZEN_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frz && !data_we |=> $stable(sec)); // R9
  AST_MASK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> nmi_mask == $past(wdata[7])); // R1
  AST_POWER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    power_lost |=> !vrt); // R11
endmodule

bind rtc_core rtc_core_chk #(.LEAD_CYC(LEAD_CYC), .HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .idx_we(idx_we), .data_we(data_we),
  .wdata(wdata), .power_lost(power_lost), .nmi_mask(nmi_mask), .uip(busy),
  .frz(r_b[7]), .sec(r_sec), .vrt(r_vrt)
);

// File: tb/rtc_core_bench.sv
module rtc_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEAD = 4;
  localparam int HOLD = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, power_lost = 1'b0, idx_we = 1'b0, data_we = 1'b0, data_re = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic nmi_mask;

  int checks = 0, errors = 0, cur_idx = -1;
  int m_sec, m_min, m_hr, m_wd, m_day, m_mon, m_yr, m_busy, m_cnt, m_idx;
  bit m_bin, m_24, m_frz, m_vrt;

  rtc_core #(.LEAD_CYC(LEAD), .HOLD_CYC(HOLD)) u_rtc_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .power_lost(power_lost),
    .idx_we(idx_we), .data_we(data_we), .data_re(data_re),
    .wdata(wdata), .rdata(rdata), .nmi_mask(nmi_mask));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int enc(int v);
    return m_bin ? v : (v / 10) * 16 + v % 10;
  endfunction
  function automatic int enc_hr(int h);
    int h12;
    if (m_24) return enc(h);
    h12 = h % 12;
    if (h12 == 0) h12 = 12;
    return (h >= 12 ? 128 : 0) + enc(h12);
  endfunction
  function automatic int dec(int b);
    return m_bin ? b : (b / 16) * 10 + b % 16;
  endfunction
  function automatic int dec_hr(int b);
    int h;
    h = dec(b % 128);
    if (m_24) return h;
    if (b >= 128) return (h == 12) ? 12 : h + 12;
    return (h == 12) ? 0 : h;
  endfunction
  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic void advance();
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0;
    m_wd = (m_wd == 7) ? 1 : m_wd + 1;
    m_day++;
    if (m_day <= mdays(m_mon, m_yr)) return;
    m_day = 1; m_mon++;
    if (m_mon <= 12) return;
    m_mon = 1; m_yr = (m_yr + 1) % 100;
  endfunction

  function automatic void model_write(int i, int v);
    case (i)
      0: m_sec = dec(v);
      2: m_min = dec(v);
      4: m_hr  = dec_hr(v);
      6: m_wd  = dec(v);
      7: m_day = dec(v);
      8: m_mon = dec(v);
      9: m_yr  = dec(v);
      11: begin m_frz = v[7]; m_bin = v[2]; m_24 = v[1]; end
      default: ;
    endcase
  endfunction

  always @(posedge clk) begin
    bit frz_now;
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_wd = 1; m_day = 1; m_mon = 1; m_yr = 0;
      m_bin = 0; m_24 = 1; m_frz = 0; m_vrt = 0; m_busy = 0; m_cnt = 0; m_idx = 0;
    end else begin
      frz_now = m_frz;
      if (m_busy != 0) begin
        if (m_cnt == LEAD - 1 && !frz_now) advance();
        if (m_cnt == LEAD + HOLD - 1) m_busy = 0;
        m_cnt++;
      end else if (tick && !frz_now) begin
        m_busy = 1; m_cnt = 0;
      end
      if (data_we) model_write(m_idx, int'(wdata));
      if (power_lost) m_vrt = 0;
      else if (data_re && m_idx == 13) m_vrt = 1;
      if (idx_we) m_idx = int'(wdata[6:0]);
    end
    #(CLK_PERIOD/4);
    if (rst_n && cur_idx == 10) chk("R3 update flag per cycle", int'(rdata[7]), m_busy);
  end

  task automatic wr_idx(int i);
    cur_idx = -1;
    @(negedge clk); idx_we = 1'b1; wdata = 8'(i);
    @(negedge clk); idx_we = 1'b0;
  endtask
  task automatic wr_reg(int i, int v);
    wr_idx(i);
    data_we = 1'b1; wdata = 8'(v);
    @(negedge clk); data_we = 1'b0;
  endtask
  task automatic rd(int i, output int v);
    wr_idx(i);
    data_re = 1'b1; v = int'(rdata);
    @(negedge clk); data_re = 1'b0;
  endtask
  task automatic park();
    wr_idx(10); cur_idx = 10;
  endtask
  task automatic wait_idle();
    repeat (LEAD + HOLD + 2) @(negedge clk);
  endtask
  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    wait_idle();
  endtask
  task automatic set_time(int h, int mi, int s, int wd, int d, int mo, int y);
    wr_reg(0, enc(s)); wr_reg(2, enc(mi)); wr_reg(4, enc_hr(h)); wr_reg(6, enc(wd));
    wr_reg(7, enc(d)); wr_reg(8, enc(mo)); wr_reg(9, enc(y));
  endtask
  task automatic check_time(string tag);
    int v;
    rd(0, v); chk({tag, " sec"}, v, enc(m_sec));
    rd(2, v); chk({tag, " min"}, v, enc(m_min));
    rd(4, v); chk({tag, " hour"}, v, enc_hr(m_hr));
    rd(6, v); chk({tag, " wday"}, v, enc(m_wd));
    rd(7, v); chk({tag, " day"}, v, enc(m_day));
    rd(8, v); chk({tag, " month"}, v, enc(m_mon));
    rd(9, v); chk({tag, " year"}, v, enc(m_yr));
  endtask
  task automatic tick_case(string tag, int h, int mi, int s, int wd, int d, int mo, int y);
    set_time(h, mi, s, wd, d, mo, y);
    park(); do_tick(); check_time(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    check_time("R2 reset");
    rd(11, v); chk("R2 control reset", v, 8'h02);
    rd(10, v); chk("R2 status reset", v, 8'h26);
    rd(13, v); chk("R2 R11 power-valid after reset", v, 8'h00);
    rd(13, v); chk("R11 power-valid after read", v, 8'h80);

    // R1 index port and unmapped registers
    wr_idx(8'h89); chk("R1 mask bit set", int'(nmi_mask), 1); chk("R1 address ignores bit 7", int'(rdata), 8'h00);
    wr_idx(8'h08); chk("R1 mask bit clear", int'(nmi_mask), 0); chk("R1 month read", int'(rdata), 8'h01);
    wr_reg(1, 8'h55); rd(1, v); chk("R1 index 1 ignores writes", v, 8'h00);
    wr_reg(12, 8'h77); rd(12, v); chk("R1 index 12 reads zero", v, 8'h00);

    // R6 full rollover, R8 BCD storage
    set_time(23, 59, 59, 7, 31, 12, 99);
    rd(4, v); chk("R8 BCD hour byte", v, 8'h23);
    park(); do_tick(); check_time("R6 year rollover");
    rd(4, v); chk("R4 hour wraps", v, 8'h00);
    rd(6, v); chk("R6 weekday wraps", v, 8'h01);
    rd(9, v); chk("R6 year wraps", v, 8'h00);

    // R3 update timing
    set_time(8, 0, 10, 3, 5, 5, 5);
    wr_idx(0);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (LEAD - 1) @(negedge clk);
    chk("R3 before update edge", int'(rdata), 8'h10);
    @(negedge clk);
    chk("R3 after update edge", int'(rdata), 8'h11);
    wait_idle();
    park();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    n = 0;
    while (rdata[7] && n < 1000) begin
      n++;
      if (n == 2) tick = 1'b1; else tick = 1'b0;
      @(negedge clk);
    end
    tick = 1'b0;
    chk("R3 flag length", n, LEAD + HOLD);
    wait_idle();
    rd(0, v); chk("R3 tick during flag ignored", v, 8'h12);

    // R4 carries
    tick_case("R4 hour carry", 10, 59, 59, 2, 10, 3, 20);
    tick_case("R4 minute carry", 13, 45, 59, 2, 10, 3, 20);

    // R5 month lengths
    tick_case("R5 leap Feb 28", 23, 59, 59, 1, 28, 2, 24);
    rd(7, v); chk("R5 leap day", v, 8'h29);
    tick_case("R5 leap Feb 29", 23, 59, 59, 1, 29, 2, 24);
    rd(8, v); chk("R5 after Feb 29", v, 8'h03);
    tick_case("R5 common Feb 28", 23, 59, 59, 1, 28, 2, 23);
    rd(7, v); chk("R5 common to Mar 1", v, 8'h01);
    tick_case("R5 Apr 30", 23, 59, 59, 4, 30, 4, 30);
    tick_case("R5 Jan 31", 23, 59, 59, 4, 31, 1, 30);

    // R7 12-hour form
    wr_reg(11, 8'h00);
    set_time(23, 59, 59, 3, 14, 6, 41);
    rd(4, v); chk("R7 11 PM byte", v, 8'h91);
    park(); do_tick(); check_time("R7 midnight");
    rd(4, v); chk("R7 12 AM byte", v, 8'h12);
    tick_case("R7 noon to 1 PM", 12, 59, 59, 3, 14, 6, 41);
    rd(4, v); chk("R7 1 PM byte", v, 8'h81);
    tick_case("R7 11 AM to noon", 11, 59, 59, 3, 14, 6, 41);
    rd(4, v); chk("R7 12 PM byte", v, 8'h92);

    // R8 binary storage and no conversion on mode change
    wr_reg(11, 8'h06);
    tick_case("R8 binary", 0, 58, 59, 5, 9, 9, 9);
    rd(2, v); chk("R8 binary minute 59", v, 8'h3B);
    wr_reg(11, 8'h02);
    wr_reg(0, 8'h45);
    wr_reg(11, 8'h06);
    rd(0, v); chk("R8 mode change keeps byte", v, 8'h45);
    wr_reg(11, 8'h02);

    // R9 freeze
    set_time(9, 30, 20, 2, 2, 2, 2);
    wr_reg(11, 8'h82);
    park();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R9 no flag while frozen", int'(rdata[7]), 0);
    wait_idle();
    rd(0, v); chk("R9 frozen seconds hold", v, 8'h20);
    wr_reg(0, 8'h30);
    wr_reg(11, 8'h02);
    rd(0, v); chk("R9 write while frozen", v, 8'h30);
    wr_idx(11);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0; data_we = 1'b1; wdata = 8'h82;
    @(negedge clk); data_we = 1'b0;
    wait_idle();
    rd(0, v); chk("R9 pending update dropped", v, 8'h30);
    wr_reg(11, 8'h02);

    // R10 collision of host write and update
    set_time(10, 20, 59, 4, 4, 4, 4);
    wr_idx(0);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (LEAD - 1) @(negedge clk);
    data_we = 1'b1; wdata = 8'h05;
    @(negedge clk); data_we = 1'b0;
    wait_idle();
    rd(0, v); chk("R10 host write wins", v, 8'h05);
    rd(2, v); chk("R10 minute still carries", v, 8'h21);
    check_time("R10 model");

    // R11 power loss
    @(negedge clk); power_lost = 1'b1;
    @(negedge clk); power_lost = 1'b0;
    rd(13, v); chk("R11 after power loss", v, 8'h00);
    rd(13, v); chk("R11 set by read", v, 8'h80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule